// File: doc/BRIEF.md
# Windowed watchdog timer controller

This block is a watchdog built from a selectable prescaler and an 8-bit up counter. Software reaches it over a byte-wide register port with three locations: a control register, a code register that can only be written, and a monitor that returns the live count. The watchdog runs out of reset. Software keeps it from firing by writing a restart code before the counter overflows. An overflow produces a one-cycle pulse on either the interrupt request or the reset request, depending on a routing bit.

An optional window rejects restarts that come too early. While the window is closed, a restart code leaves the count as it is and raises an interrupt pulse. Once the window opens, the same code clears the count. The configuration fields are locked while the enable bit is set. Stopping the watchdog takes two steps: clear the enable bit, then write the stop code. The time base comes in as a one-cycle tick on `tick_i`.

Top module: `wdt_window_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0xA7, the count reads 0 and both request outputs are low. In the control register, bit 0 is enable, bits 2:1 are period, bits 4:3 are window, bit 5 is route, bit 7 reads 1 and bit 6 reads 0.
- R2: Address 0 returns the control register. Address 2 returns the live count. Address 1 (code) and address 3 read as 0.
- R3: With period setting s, the count advances by one on every 2^(PRESCALE_LOG2+2s)-th tick while the watchdog runs. The overflow period is therefore 256 times that interval. The default PRESCALE_LOG2 of 10 gives totals of 2^18, 2^20, 2^22 and 2^24 ticks.
- R4: Writing 0x4E to address 1 with window setting 00 sets the count to 0 at any count value.
- R5: Window settings 01, 10 and 11 stay closed while the count is below 64, 128 and 192 respectively. A 0x4E written while the window is closed leaves the count unchanged and gives a one-cycle interrupt pulse in the next cycle. A 0x4E written at or above the threshold clears the count and gives no pulse.
- R6: When the count passes 255, it restarts from 0. In the next cycle there is a one-cycle pulse on `irq_o` if route is 0, or on `rst_req_o` if route is 1.
- R7: While enable reads 1, a control write changes only the enable bit. The period, window and route fields keep their values.
- R8: Clearing enable does not stop the count. Writing 0xB1 while enable is 0 stops counting and zeroes the count. Writing 0xB1 while enable is 1 has no effect.
- R9: Any value written to address 1 other than 0x4E and 0xB1 leaves the count and both request outputs unchanged.
- R10: A control write that sets enable from 0 to 1 restarts counting and takes the new period, window and route in the same write.
- R11: Every clear of the count also resets the prescaler phase. After a clear, the first increment needs a full prescale interval of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| irq_o | output | 1 | Interrupt request pulse |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The hardest cases to reach are the exact window thresholds. The count has to sit one step below a boundary when the restart code lands, and then exactly on it. The bench gets there by holding the tick low during register writes. It puts the block into a known phase with the two-step stop sequence, which zeroes both the count and the prescaler. It then issues an exact number of ticks, so the count is known without reading any internal state. Overflow routing is reached the same way, with a reduced prescale parameter so the full 256-step period fits in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 8;
  localparam logic [7:0] CODE_CLEAR = 8'h4E;
  localparam logic [7:0] CODE_STOP  = 8'hB1;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_CODE  = 2'd1,
    REG_COUNT = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic       route_rst;
    logic [1:0] window;
    logic [1:0] period;
    logic       enable;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{route_rst: 1'b1, window: 2'b00,
                                   period: 2'b11, enable: 1'b1};
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESCALE_LOG2 = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       stb_o
);
  localparam int W = PRESCALE_LOG2 + 6;

  logic [W-1:0] pre_q;
  logic [W-1:0] mask;
  logic [2:0]   rsh;

  // sel 0 keeps PRESCALE_LOG2 low bits, each step adds two
  assign rsh   = 3'd6 - {sel_i, 1'b0};
  assign mask  = {W{1'b1}} >> rsh;
  assign stb_o = tick_i && run_i && !clr_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pre_q <= '0;
    else if (clr_i)            pre_q <= '0;
    else if (tick_i && run_i)  pre_q <= pre_q + 1'b1;
  end

  // R11
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));

  // R3
  pre_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_upcounter.sv
module wdt_upcounter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = inc_i && !clr_i && (cnt_q == {CNT_W{1'b1}});
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic [1:0] cnt_top_i,
  output ctrl_t      ctrl_o,
  output logic       active_o,
  output logic       cnt_clr_o,
  output logic       early_o
);
  ctrl_t ctrl_q;
  logic  active_q;
  logic  wr_ctrl, wr_code, code_clear, code_stop, stop_hit, win_closed;

  assign wr_ctrl    = wr_en_i && (addr_i == REG_CTRL);
  assign wr_code    = wr_en_i && (addr_i == REG_CODE);
  assign code_clear = wr_code && (wdata_i == CODE_CLEAR);
  assign code_stop  = wr_code && (wdata_i == CODE_STOP);
  assign stop_hit   = code_stop && !ctrl_q.enable;

  always_comb begin
    unique case (ctrl_q.window)
      2'b00:   win_closed = 1'b0;
      2'b01:   win_closed = (cnt_top_i == 2'b00);
      2'b10:   win_closed = !cnt_top_i[1];
      default: win_closed = (cnt_top_i != 2'b11);
    endcase
  end

  assign early_o   = code_clear && active_q && win_closed;
  assign cnt_clr_o = (code_clear && !early_o) || stop_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_ctrl) begin
      ctrl_q.enable <= wdata_i[0];
      if (!ctrl_q.enable) begin
        ctrl_q.period    <= wdata_i[2:1];
        ctrl_q.window    <= wdata_i[4:3];
        ctrl_q.route_rst <= wdata_i[5];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      active_q <= 1'b1;
    else if (wr_ctrl && wdata_i[0])   active_q <= 1'b1;
    else if (stop_hit)                active_q <= 1'b0;
  end

  assign ctrl_o   = ctrl_q;
  assign active_o = active_q;

  // R7
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.enable && wr_ctrl) |=> ($stable(ctrl_q.period) &&
                                    $stable(ctrl_q.window) &&
                                    $stable(ctrl_q.route_rst)));

  // R8
  stop_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_stop && ctrl_q.enable) |=> (active_q == $past(active_q)));

  // R10
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[0]) |=> active_q);
endmodule

// File: rtl/wdt_window_ctrl.sv
module wdt_window_ctrl
  import wdt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  ctrl_t            ctrl;
  logic             active, cnt_clr, early, stb, ovf;
  logic [CNT_W-1:0] cnt;
  logic             irq_q, rst_q;

  wdt_ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_top_i(cnt[CNT_W-1 -: 2]),
    .ctrl_o   (ctrl),
    .active_o (active),
    .cnt_clr_o(cnt_clr),
    .early_o  (early)
  );

  wdt_prescaler #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .run_i (active),
    .clr_i (cnt_clr),
    .sel_i (ctrl.period),
    .stb_o (stb)
  );

  wdt_upcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (stb),
    .clr_i (cnt_clr),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= early || (ovf && !ctrl.route_rst);
      rst_q <= ovf && ctrl.route_rst;
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL:  rdata_o = {2'b10, ctrl};
      REG_COUNT: rdata_o = cnt;
      default:   rdata_o = 8'h00;
    endcase
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  // R6
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R8
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !cnt_clr) |=> $stable(cnt));

  // R6
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !$past(early)) |-> !irq_o);
endmodule

// File: tb/wdt_window_ctrl_tb_top.sv
module wdt_window_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, rst_req;
  int         n_tests = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  wdt_window_ctrl #(.PRESCALE_LOG2(2)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_o    (irq),
    .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hB1);
    wr(2'd0, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);
    rd(2'd0, d); chk("R1 ctrl", d, 8'hA7);
    rd(2'd2, d); chk("R1 count", d, 8'h00);
    rd(2'd1, d); chk("R2 code reads 0", d, 8'h00);
    rd(2'd3, d); chk("R2 addr3 reads 0", d, 8'h00);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    wr(2'd0, 8'h19);
    rd(2'd0, d); chk("R7 locked cfg", d, 8'hA7);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R7 only enable changes", d, 8'hA6);
    ticks(512);
    rd(2'd2, d); chk("R8 counts with enable 0", d, 8'd2);
    wr(2'd1, 8'hB1);
    rd(2'd2, d); chk("R8 stop zeroes", d, 8'd0);
    ticks(512);
    rd(2'd2, d); chk("R8 stopped", d, 8'd0);
  endtask

  task automatic t_restart;
    logic [7:0] d;
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R10 cfg taken with enable", d, 8'h81);
    ticks(20);
    rd(2'd2, d); chk("R10 R3 counting", d, 8'd5);
    wr(2'd1, 8'hB1);
    rd(2'd2, d); chk("R8 stop ignored when enabled", d, 8'd5);
    ticks(4);
    rd(2'd2, d); chk("R8 still running", d, 8'd6);
  endtask

  task automatic t_invalid;
    logic [7:0] d;
    wr(2'd1, 8'h55);
    chk("R9 no irq", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    chk("R9 no rst_req", {7'd0, rst_req}, 8'h00);
    rd(2'd2, d); chk("R9 count kept", d, 8'd6);
  endtask

  task automatic t_phase;
    logic [7:0] d;
    ticks(2);
    wr(2'd1, 8'h4E);
    rd(2'd2, d); chk("R4 clear", d, 8'd0);
    ticks(3);
    rd(2'd2, d); chk("R11 phase reset", d, 8'd0);
    ticks(1);
    rd(2'd2, d); chk("R11 first step", d, 8'd1);
  endtask

  task automatic t_clear_top;
    logic [7:0] d;
    set_cfg(8'h01);
    ticks(4 * 255);
    rd(2'd2, d); chk("R3 count 255", d, 8'd255);
    wr(2'd1, 8'h4E);
    chk("R4 no irq", {7'd0, irq}, 8'h00);
    rd(2'd2, d); chk("R4 cleared at 255", d, 8'd0);
  endtask

  task automatic t_ovf_irq;
    logic [7:0] d;
    set_cfg(8'h01);
    ticks(1023);
    chk("R6 no early irq", {7'd0, irq}, 8'h00);
    ticks(1);
    chk("R6 irq pulse", {7'd0, irq}, 8'h01);
    chk("R6 no rst_req", {7'd0, rst_req}, 8'h00);
    rd(2'd2, d); chk("R6 restart 0", d, 8'd0);
    chk("R6 irq one cycle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ovf_rst;
    logic [7:0] d;
    set_cfg(8'h21);
    rd(2'd0, d); chk("R10 route taken", d, 8'hA1);
    ticks(1024);
    chk("R6 rst_req pulse", {7'd0, rst_req}, 8'h01);
    chk("R6 irq quiet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 rst_req one cycle", {7'd0, rst_req}, 8'h00);
  endtask

  task automatic t_window(input logic [7:0] cfg, input int thr);
    logic [7:0] d;
    set_cfg(cfg);
    ticks(4 * (thr - 1));
    wr(2'd1, 8'h4E);
    chk("R5 early irq", {7'd0, irq}, 8'h01);
    rd(2'd2, d); chk("R5 early keeps count", d, 8'(thr - 1));
    chk("R5 irq one cycle", {7'd0, irq}, 8'h00);
    ticks(4);
    wr(2'd1, 8'h4E);
    chk("R5 open no irq", {7'd0, irq}, 8'h00);
    rd(2'd2, d); chk("R5 open clears", d, 8'd0);
  endtask

  task automatic t_period;
    logic [7:0] d;
    set_cfg(8'h03);
    ticks(16 * 256 - 1);
    rd(2'd2, d); chk("R3 period 01 count", d, 8'd255);
    chk("R3 period 01 no ovf", {7'd0, irq}, 8'h00);
    ticks(1);
    chk("R3 period 01 ovf", {7'd0, irq}, 8'h01);
    set_cfg(8'h05);
    ticks(64 * 5 + 63);
    rd(2'd2, d); chk("R3 period 10", d, 8'd5);
    set_cfg(8'h07);
    ticks(256 * 3);
    rd(2'd2, d); chk("R3 period 11", d, 8'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_disable();
    t_restart();
    t_invalid();
    t_phase();
    t_clear_top();
    t_ovf_irq();
    t_ovf_rst();
    t_window(8'h09, 64);
    t_window(8'h11, 128);
    t_window(8'h19, 192);
    t_period();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule